// File: doc/BRIEF.md
# Program Counter with Circular Return Stack

This block is the instruction-address sequencer of a small 8-bit controller core. It holds a 13-bit logical program counter and an 8-entry return-address stack. Each cycle, one-hot-ish control strobes from the decoder pick the next counter value. The choices are to hold, advance by one, load a branch target, load a target while saving the return address, take an interrupt, or restore a saved address. The restore path is shared by every flavour of return: plain, from interrupt, and with a literal. Loading the literal into the working register is handled elsewhere.

Only 1K words of program storage exist, so the fetch address sent to memory is the low 10 bits of the counter. The counter itself and every stack entry keep all 13 bits. Code that runs past 03FFh therefore keeps counting logically, while its fetches alias back into the implemented window.

The stack is a circular buffer with no overflow or underflow indication. All pins are plain control and status signals. There is no streaming data path, so no valid/ready handshake is used.

Top module: `pc_stack_unit`

## Requirements
- R1: While `rst_n` is low, `pc_full` is 0000h. Every stack entry is cleared to 0000h and the stack is empty.
- R2: `irq_take` wins over `call`, `jump`, `ret` and `step` asserted in the same cycle.
- R3: On `irq_take`, the current `pc_full` is pushed and `pc_full` becomes 0004h on the next cycle.
- R4: On `step` alone, `pc_full` advances by one, modulo 8192 (1FFFh wraps to 0000h).
- R5: On `jump`, `pc_full` takes `tgt_addr` and the stack is untouched.
- R6: On `call`, `pc_full`+1 (modulo 8192) is pushed and `pc_full` takes `tgt_addr`.
- R7: On `ret`, the most recently pushed live entry is popped into `pc_full`.
- R8: Nested pushes come back in reverse order.
- R9: The stack holds 8 entries and wraps. A ninth push overwrites the oldest entry. After nine pushes, nine pops return pushes 9, 8, …, 2 and then push 9 again.
- R10: A `ret` right after reset, with nothing pushed, loads 0000h.
- R11: `fetch_addr` equals `pc_full[9:0]`. Values above 03FFh are kept whole in `pc_full` and on the stack.
- R12: With no strobe asserted, `pc_full` holds its value.
- R13: Among the non-interrupt strobes the priority is `call` > `jump` > `ret` > `step`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_take | input | 1 | Interrupt entry strobe |
| call | input | 1 | Subroutine call strobe (uses `tgt_addr`) |
| jump | input | 1 | Branch strobe (uses `tgt_addr`) |
| ret | input | 1 | Return strobe (any return form) |
| step | input | 1 | Sequential advance strobe |
| tgt_addr | input | 13 | Branch or call target |
| fetch_addr | output | 10 | Physical program-memory fetch address |
| pc_full | output | 13 | Full logical program counter |

## Verification
The hardest situation to reach from the ports is a stack that has wrapped. Getting there takes at least nine pushes without pops between them. Random stimulus with balanced call and return rates seldom produces that, so a directed sequence makes nine calls in a row to distinct targets and then nine returns, one per cycle.

The same bench also covers the aliasing corner. It jumps above 03FFh and calls from there, so a fetch address that has folded and a full 13-bit return value are both observed. Random mixes with overlapping strobes cover the priority order against a bench-side model.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_STEP,
    OP_JUMP,
    OP_CALL,
    OP_RET,
    OP_IRQ
  } pc_op_e;
endpackage

// File: rtl/pcs_arbiter.sv
// Resolves simultaneous control strobes into a single operation.
module pcs_arbiter
  import pcs_pkg::*;
(
  input  logic   irq_take,
  input  logic   call,
  input  logic   jump,
  input  logic   ret,
  input  logic   step,
  output pc_op_e op
);
  always_comb begin
    if (irq_take)  op = OP_IRQ;
    else if (call) op = OP_CALL;
    else if (jump) op = OP_JUMP;
    else if (ret)  op = OP_RET;
    else if (step) op = OP_STEP;
    else           op = OP_HOLD;
  end
endmodule

// File: rtl/pcs_stack.sv
// Circular return-address stack; pointer addresses the next free slot.
module pcs_stack #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  // Wrapping decrement; DEPTH is a power of two so natural overflow wraps.
  assign rd_ptr   = wr_ptr - PTR_W'(1);
  assign top_data = slots[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
    end else if (push) begin
      wr_ptr <= wr_ptr + PTR_W'(1);
    end else if (pop) begin
      wr_ptr <= rd_ptr;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slots[g] <= '0;
      end else if (push && (wr_ptr == PTR_W'(g))) begin
        slots[g] <= push_data;
      end
    end
  end
endmodule

// File: rtl/pcs_next.sv
// Next-counter selection and the value to be saved on a push.
module pcs_next
  import pcs_pkg::*;
#(
  parameter int              PC_W    = 13,
  parameter logic [PC_W-1:0] RST_VEC = '0,
  parameter logic [PC_W-1:0] IRQ_VEC = PC_W'(4)
) (
  input  pc_op_e          op,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] tgt,
  input  logic [PC_W-1:0] stack_top,
  output logic [PC_W-1:0] pc_nxt,
  output logic            push,
  output logic            pop,
  output logic [PC_W-1:0] push_val
);
  logic [PC_W-1:0] pc_inc;
  assign pc_inc = pc + PC_W'(1);

  always_comb begin
    pc_nxt   = pc;
    push     = 1'b0;
    pop      = 1'b0;
    push_val = pc_inc;
    unique case (op)
      OP_IRQ: begin
        pc_nxt   = IRQ_VEC;
        push     = 1'b1;
        push_val = pc;
      end
      OP_CALL: begin
        pc_nxt = tgt;
        push   = 1'b1;
      end
      OP_JUMP: pc_nxt = tgt;
      OP_RET: begin
        pc_nxt = stack_top;
        pop    = 1'b1;
      end
      OP_STEP: pc_nxt = pc_inc;
      default: pc_nxt = pc;
    endcase
  end
endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit
  import pcs_pkg::*;
#(
  parameter int              PC_W    = 13,
  parameter int              PHYS_W  = 10,
  parameter int              DEPTH   = 8,
  parameter logic [PC_W-1:0] RST_VEC = '0,
  parameter logic [PC_W-1:0] IRQ_VEC = PC_W'(4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_take,
  input  logic              call,
  input  logic              jump,
  input  logic              ret,
  input  logic              step,
  input  logic [PC_W-1:0]   tgt_addr,
  output logic [PHYS_W-1:0] fetch_addr,
  output logic [PC_W-1:0]   pc_full
);
  pc_op_e          op;
  logic [PC_W-1:0] pc_q, pc_nxt, push_val, stack_top;
  logic            push, pop;

  pcs_arbiter u_arb (
    .irq_take (irq_take),
    .call     (call),
    .jump     (jump),
    .ret      (ret),
    .step     (step),
    .op       (op)
  );

  pcs_next #(.PC_W(PC_W), .RST_VEC(RST_VEC), .IRQ_VEC(IRQ_VEC)) u_next (
    .op        (op),
    .pc        (pc_q),
    .tgt       (tgt_addr),
    .stack_top (stack_top),
    .pc_nxt    (pc_nxt),
    .push      (push),
    .pop       (pop),
    .push_val  (push_val)
  );

  pcs_stack #(.W(PC_W), .DEPTH(DEPTH)) u_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .push_data (push_val),
    .top_data  (stack_top)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RST_VEC;
    else        pc_q <= pc_nxt;
  end

  assign pc_full = pc_q;

  // Physical window fold: keep only the implemented address bits.
  if (PHYS_W < PC_W) begin : g_fold
    assign fetch_addr = pc_q[PHYS_W-1:0];
  end else begin : g_pass
    assign fetch_addr = PHYS_W'(pc_q);
  end
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int              PC_W    = 13,
  parameter logic [PC_W-1:0] IRQ_VEC = PC_W'(4)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_take,
  input logic            call,
  input logic            jump,
  input logic            ret,
  input logic            step,
  input logic [PC_W-1:0] tgt_addr,
  input logic [PC_W-1:0] pc_full
);
  logic any_strobe;
  assign any_strobe = irq_take | call | jump | ret | step;

  a_r1_reset_vec: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> pc_full == '0);

  a_r3_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> pc_full == IRQ_VEC);

  a_r4_step_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !irq_take && !call && !jump && !ret) |=> pc_full == $past(pc_full) + PC_W'(1));

  a_r5_jump_load: assert property (@(posedge clk) disable iff (!rst_n)
    (jump && !irq_take && !call) |=> pc_full == $past(tgt_addr));

  a_r7_call_then_ret: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(call && !irq_take) && ret && !irq_take && !call && !jump)
      |=> pc_full == $past(pc_full, 2) + PC_W'(1));

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !any_strobe |=> $stable(pc_full));
endmodule

bind pc_stack_unit pcs_checker #(.PC_W(PC_W), .IRQ_VEC(IRQ_VEC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_take (irq_take),
  .call     (call),
  .jump     (jump),
  .ret      (ret),
  .step     (step),
  .tgt_addr (tgt_addr),
  .pc_full  (pc_full)
);

// File: tb/pc_stack_unit_tb.sv
module pc_stack_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_take = 0, call = 0, jump = 0, ret = 0, step = 0;
  logic [12:0] tgt_addr = '0;
  logic [9:0]  fetch_addr;
  logic [12:0] pc_full;

  int nvec = 0;
  int nfail = 0;
  bit done = 0;

  logic [12:0] m_pc;
  logic [12:0] m_stk [8];
  int          m_sp;

  always #5 clk = ~clk;

  pc_stack_unit u_dut (
    .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .call(call), .jump(jump),
    .ret(ret), .step(step), .tgt_addr(tgt_addr), .fetch_addr(fetch_addr),
    .pc_full(pc_full)
  );

  task automatic check(string tag, logic [12:0] act, logic [12:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference model step; returns the requirement tag of the operation taken.
  function automatic string model(bit i, bit c, bit j, bit r, bit s, logic [12:0] t);
    if (i) begin
      m_stk[m_sp] = m_pc; m_sp = (m_sp + 1) % 8; m_pc = 13'h0004; return "R3";
    end else if (c) begin
      m_stk[m_sp] = m_pc + 13'd1; m_sp = (m_sp + 1) % 8; m_pc = t; return "R6";
    end else if (j) begin
      m_pc = t; return "R5";
    end else if (r) begin
      m_sp = (m_sp + 7) % 8; m_pc = m_stk[m_sp]; return "R7";
    end else if (s) begin
      m_pc = m_pc + 13'd1; return "R4";
    end
    return "R12";
  endfunction

  task automatic apply(bit i, bit c, bit j, bit r, bit s, logic [12:0] t, string tag_o = "");
    string tag;
    @(negedge clk);
    irq_take = i; call = c; jump = j; ret = r; step = s; tgt_addr = t;
    tag = model(i, c, j, r, s, t);
    if (tag_o != "") tag = tag_o;
    @(posedge clk);
    @(negedge clk);
    irq_take = 0; call = 0; jump = 0; ret = 0; step = 0;
    check(tag, pc_full, m_pc);
    check("R11", {3'b0, fetch_addr}, {3'b0, m_pc[9:0]});
  endtask

  initial begin
    m_pc = '0; m_sp = 0;
    for (int k = 0; k < 8; k++) m_stk[k] = '0;
    repeat (3) @(negedge clk);
    check("R1", pc_full, 13'h0000);
    check("R1", {3'b0, fetch_addr}, 13'h0000);
    rst_n = 1'b1;
    // R10: pop from empty stack after reset
    apply(0, 0, 0, 1, 0, 13'h0, "R10");
    // R4: wrap of the logical counter
    apply(0, 0, 1, 0, 0, 13'h1FFF);
    apply(0, 0, 0, 0, 1, 13'h0, "R4");
    // R11: fold above 03FFh, full value on the stack
    apply(0, 0, 1, 0, 0, 13'h1234, "R11");
    apply(0, 1, 0, 0, 0, 13'h07FE, "R11");
    apply(0, 0, 0, 1, 0, 13'h0, "R11");
    // R12: idle hold
    apply(0, 0, 0, 0, 0, 13'h0AAA, "R12");
    // R2: everything at once, interrupt wins
    apply(1, 1, 1, 1, 1, 13'h0321, "R2");
    apply(0, 0, 0, 1, 0, 13'h0, "R3");
    // R13: call beats jump and ret; jump beats ret and step
    apply(0, 1, 1, 1, 1, 13'h0150, "R13");
    apply(0, 0, 1, 1, 1, 13'h0260, "R13");
    apply(0, 0, 0, 1, 1, 13'h0, "R13");
    // R8: nested calls returned in reverse order
    for (int k = 0; k < 3; k++) apply(0, 1, 0, 0, 0, 13'h0400 + 13'(k * 32));
    for (int k = 0; k < 3; k++) apply(0, 0, 0, 1, 0, 13'h0, "R8");
    // R9: nine pushes then nine pops
    for (int k = 0; k < 9; k++) apply(0, 1, 0, 0, 0, 13'h0100 + 13'(k * 16));
    for (int k = 0; k < 9; k++) apply(0, 0, 0, 1, 0, 13'h0, "R9");
    // Constrained random mix
    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 2000; n++) begin
      int w;
      bit i, c, j, r, s;
      w = int'($urandom_range(0, 99));
      i = (w < 4);
      c = ($urandom_range(0, 99) < 18);
      j = ($urandom_range(0, 99) < 12);
      r = ($urandom_range(0, 99) < 20);
      s = ($urandom_range(0, 99) < 60);
      apply(i, c, j, r, s, 13'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nvec++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule